// File: doc/BRIEF.md
# Low-Toggle Pipeline Stage Register

This block is one stage of a processor pipeline. A single occupancy flag, which is reset, says whether the stage holds an instruction. Next to it sits a wide payload register that has no reset. The payload is written only on the cycle a new instruction is accepted. It is never cleared when the instruction moves on, so its flops toggle only when fresh content actually arrives.

Upstream and downstream both use a valid/ready handshake. A flush input discards the occupant at once, by clearing only the occupancy flag. While flush is high, the stage refuses new work. Any logic that looks at the payload must first qualify it with the downstream valid, because the payload flops carry no reset and can hold unknown values until the first load.

The payload is split into lanes of a parameterised width that share one load enable. This lets a synthesis tool infer one clock-gating group per lane from the load-enable coding style.

Top module: `lowtoggle_stage`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `out_valid` is 0 after that edge, regardless of the other inputs.
- R2: `in_ready` is 1 exactly when `flush` is 0 and either `out_valid` is 0 or `out_ready` is 1.
- R3: A load happens at a rising edge where `in_valid` and `in_ready` are both 1. After that edge, `out_valid` is 1 and `out_data` equals the `in_data` sampled at the edge.
- R4: At an edge where `out_valid` and `out_ready` are both 1 and no load happens, `out_valid` becomes 0.
- R5: `out_data` changes only at load edges. After a departure, the stale payload stays on `out_data` until the next load.
- R6: While `out_valid` is 1, `out_ready` is 0 and `flush` is 0, both `out_valid` and `out_data` hold.
- R7: At an edge where `flush` is 1, `out_valid` becomes 0, no load happens, and `out_data` is unchanged.
- R8: When a departure and a load happen at the same edge, `out_valid` stays 1 and `out_data` takes the new `in_data`.
- R9: Whenever `out_valid` is 1 after reset, no bit of `out_data` is unknown.
- R10: Changes on `in_data` at edges without a load have no effect on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the occupancy flag only |
| flush | input | 1 | Discard the current occupant and block loads this cycle |
| in_valid | input | 1 | Upstream offers an instruction |
| in_ready | output | 1 | Stage can accept an instruction this cycle |
| in_data | input | PAYLOAD_W | Upstream instruction payload |
| out_valid | output | 1 | Stage holds an instruction |
| out_ready | input | 1 | Downstream takes the instruction this cycle |
| out_data | output | PAYLOAD_W | Held payload, meaningful only while out_valid is 1 |

## Verification
The assertions assume that `in_data` is free of unknown bits on any cycle where `in_valid` and `in_ready` are both high. Without that, the unknown-payload property could not hold. They also assume that `out_ready` and `flush` are driven to known levels once reset is released. The stimulus drives every input to a defined value on the falling edge from time zero. It only ever offers defined payload words, so the payload's lack of reset is visible only before the first load, while `out_valid` is still low.

// File: rtl/lts_pkg.sv
// Package: shared event type for the low-toggle stage.
// Assumes: nothing beyond a single clock domain.
package lts_pkg;

    // Per-cycle events decided by the occupancy control.
    typedef struct packed {
        logic load;   // new instruction captured this edge
        logic drain;  // occupant leaves downstream this edge
        logic kill;   // occupant discarded by flush this edge
    } stage_ev_t;

    // Number of lanes needed to cover a payload of the given width.
    function automatic int lane_count(input int width, input int lane_w);
        return (width + lane_w - 1) / lane_w;
    endfunction

endpackage

// File: rtl/lts_valid_ctrl.sv
// Module: occupancy flag and handshake decode for one pipeline stage.
// Assumes: rst_n is synchronous and active low; flush overrides loading.
module lts_valid_ctrl
    import lts_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      in_valid,
    input  logic      out_ready,
    output logic      in_ready,
    output logic      occ_q,
    output stage_ev_t ev
);

    // Decode acceptance, departure and kill from the handshake.
    always_comb begin
        in_ready = !flush && (!occ_q || out_ready);
        ev.load  = in_valid && in_ready;
        ev.drain = occ_q && out_ready;
        ev.kill  = flush;
    end

    // Occupancy flag: reset and flush clear, load sets, departure clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= 1'b0;
        end else if (ev.kill) begin
            occ_q <= 1'b0;
        end else if (ev.load) begin
            occ_q <= 1'b1;
        end else if (ev.drain) begin
            occ_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lts_payload_reg.sv
// Module: payload register without reset, split into lanes with a shared load enable.
// Assumes: consumers qualify the contents with the occupancy flag; no reset exists here.
module lts_payload_reg #(
    parameter int WIDTH  = 64,
    parameter int LANE_W = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int LANES = lts_pkg::lane_count(WIDTH, LANE_W);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        localparam int HI = (LO + LANE_W > WIDTH) ? WIDTH - 1 : LO + LANE_W - 1;

        // Lane storage: capture only on load, otherwise keep the old bits.
        always_ff @(posedge clk) begin
            if (load) begin
                q[HI:LO] <= d[HI:LO];
            end
        end
    end

endmodule

// File: rtl/lowtoggle_stage.sv
// Module: pipeline stage register with a reset occupancy flag and an unreset payload.
// Assumes: downstream ignores out_data while out_valid is low.
module lowtoggle_stage #(
    parameter int PAYLOAD_W = 64,
    parameter int LANE_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PAYLOAD_W-1:0] in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PAYLOAD_W-1:0] out_data
);

    lts_pkg::stage_ev_t ev;
    logic               occ_q;

    lts_valid_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .occ_q     (occ_q),
        .ev        (ev)
    );

    lts_payload_reg #(
        .WIDTH  (PAYLOAD_W),
        .LANE_W (LANE_W)
    ) u_payload (
        .clk  (clk),
        .load (ev.load),
        .d    (in_data),
        .q    (out_data)
    );

    // Present the occupancy flag downstream.
    always_comb out_valid = occ_q;

endmodule

// File: rtl/lts_stage_chk.sv
// Module: property checker for lowtoggle_stage, attached by bind.
// Assumes: in_data is known whenever it is accepted.
module lts_stage_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flush,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] in_data,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_data
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!flush && (!out_valid || out_ready)));

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

    // R4
    depart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

    // R5
    payload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(in_valid && in_ready)) |=> $stable(out_data));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

    // R7
    flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R9
    known_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_data));

endmodule

bind lowtoggle_stage lts_stage_chk #(.W(PAYLOAD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/tb_lowtoggle_stage.sv
`timescale 1ns/1ps
module tb_lowtoggle_stage;

    localparam int W = 32;

    typedef struct packed {
        logic         fl;
        logic         iv;
        logic         ordy;
        logic [W-1:0] d;
        logic         exp_rdy;
        logic         exp_v;
        logic [W-1:0] exp_d;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 32'hA000_0001, 1'b1, 1'b1, 32'hA000_0001}, // R3 load into empty
        '{1'b0, 1'b1, 1'b0, 32'hA000_0002, 1'b0, 1'b1, 32'hA000_0001}, // R6 R10 stall
        '{1'b0, 1'b1, 1'b1, 32'hA000_0003, 1'b1, 1'b1, 32'hA000_0003}, // R8 drain+load
        '{1'b0, 1'b0, 1'b1, 32'hA000_0004, 1'b1, 1'b0, 32'hA000_0003}, // R4 R5 depart
        '{1'b0, 1'b0, 1'b0, 32'hA000_0005, 1'b1, 1'b0, 32'hA000_0003}, // R10 empty idle
        '{1'b0, 1'b1, 1'b0, 32'hA000_0006, 1'b1, 1'b1, 32'hA000_0006}, // R3
        '{1'b1, 1'b1, 1'b0, 32'hA000_0007, 1'b0, 1'b0, 32'hA000_0006}, // R7 flush
        '{1'b0, 1'b1, 1'b1, 32'hA000_0008, 1'b1, 1'b1, 32'hA000_0008}, // R3
        '{1'b1, 1'b0, 1'b1, 32'hA000_0009, 1'b0, 1'b0, 32'hA000_0008}, // R7 flush
        '{1'b0, 1'b1, 1'b1, 32'hA000_000A, 1'b1, 1'b1, 32'hA000_000A}, // R3
        '{1'b0, 1'b1, 1'b1, 32'hA000_000B, 1'b1, 1'b1, 32'hA000_000B}, // R8
        '{1'b0, 1'b0, 1'b0, 32'hA000_000C, 1'b0, 1'b1, 32'hA000_000B}, // R6
        '{1'b0, 1'b0, 1'b1, 32'hA000_000D, 1'b1, 1'b0, 32'hA000_000B}  // R4 R5
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lowtoggle_stage #(.PAYLOAD_W(W), .LANE_W(8)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic f, input logic v, input logic r, input logic [W-1:0] d);
        @(negedge clk);
        flush = f; in_valid = v; out_ready = r; in_data = d;
        #1;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", {31'b0, out_valid}, 32'd0);
        drive(1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        after_edge();
        chk("R1 idle after reset", {31'b0, out_valid}, 32'd0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].fl, VEC[i].iv, VEC[i].ordy, VEC[i].d);
            chk($sformatf("R2 ready step %0d", i), {31'b0, in_ready}, {31'b0, VEC[i].exp_rdy});
            after_edge();
            chk($sformatf("R3-valid step %0d", i), {31'b0, out_valid}, {31'b0, VEC[i].exp_v});
            chk($sformatf("R5 data step %0d", i), out_data, VEC[i].exp_d);
            if (out_valid) chk("R9 known payload", {31'b0, $isunknown(out_data)}, 32'd0);
        end

        // R1 reset while occupied and stalled; payload untouched
        drive(1'b0, 1'b1, 1'b0, 32'h5555_1234);
        after_edge();
        chk("R3 load before reset", out_data, 32'h5555_1234);
        drive(1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
        rst_n = 1'b0;
        after_edge();
        chk("R1 reset clears valid", {31'b0, out_valid}, 32'd0);
        chk("R10 payload kept across reset", out_data, 32'h5555_1234);
        drive(1'b0, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        after_edge();

        // R10 in_data churn while stalled
        drive(1'b0, 1'b1, 1'b0, 32'h0F0F_0F0F);
        after_edge();
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 1'b1, 1'b0, 32'h1000_0000 + k);
            after_edge();
            chk("R10 churn ignored", out_data, 32'h0F0F_0F0F);
            chk("R6 still valid", {31'b0, out_valid}, 32'd1);
        end

        // R7 flush with ready downstream: payload unchanged, no load
        drive(1'b1, 1'b1, 1'b1, 32'h7777_7777);
        chk("R2 ready low on flush", {31'b0, in_ready}, 32'd0);
        after_edge();
        chk("R7 flush valid", {31'b0, out_valid}, 32'd0);
        chk("R7 flush payload", out_data, 32'h0F0F_0F0F);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule